// File: doc/BRIEF.md
# Registered 32-bit Arithmetic Logic Unit with Barrel Shifter

This block is the execute-stage arithmetic logic unit of a 32-bit integer core. Each cycle it takes two operands, a 5-bit shift distance and a 3-bit operation code. It returns a 32-bit result and a flag that is set when that result is zero. The decoder uses the flag for branch-on-equal and branch-on-not-equal: it issues a subtraction and tests the flag.

It supports eight operations:
- wrapping addition and subtraction;
- three bitwise functions: AND, OR and NOR;
- a signed less-than compare that yields 0 or 1;
- zero-filling left and right shifts of the second operand.

For immediate-form instructions, an enable input replaces the second operand with a zero-extended 16-bit constant. The result and the flag are captured in a register stage that feeds the write-back path. Both are valid one clock edge after the inputs are presented.

Top module: `alu_core`

## Requirements
- R1: With op_i = 0 the result is a_i + B truncated to 32 bits, where B is the selected second operand; a carry out of bit 31 is dropped without any indication.
- R2: With op_i = 1 the result is a_i - B modulo 2^32.
- R3: op_i = 2, 3 and 4 give the bitwise AND, OR and NOR of a_i and B. NOR against a zero operand inverts the other operand. For example, 0x0000000D and 0x80000009 give 0x00000009, 0x8000000D and 0x7FFFFFF2 respectively.
- R4: With op_i = 5 the result is 1 when a_i is less than B as two's-complement signed numbers, and 0 otherwise. Bits 31..1 are always 0.
- R5: With op_i = 6 the result is B shifted left by shamt_i places, with vacated low bits set to 0. a_i has no effect.
- R6: With op_i = 7 the result is B shifted right by shamt_i places, with vacated high bits set to 0. a_i has no effect.
- R7: When imm_en_i = 1, B is {16'h0000, imm_i} for every operation and b_i has no effect. An AND in this mode therefore clears result bits 31..16.
- R8: zero_o is 1 exactly when result_o is 0.
- R9: result_o and zero_o reflect the inputs sampled at the previous rising clock edge. They hold steady between edges regardless of input changes.
- R10: While rst_n is low, result_o is 0 and zero_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation code (0 add, 1 sub, 2 and, 3 or, 4 nor, 5 signed less-than, 6 shift left, 7 shift right) |
| imm_en_i | input | 1 | Use the zero-extended immediate as the second operand |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand (register form) |
| imm_i | input | 16 | Immediate constant |
| shamt_i | input | 5 | Shift distance |
| result_o | output | 32 | Registered result |
| zero_o | output | 1 | Registered flag, 1 when result_o is 0 |

## Verification
Every result and its zero flag are due exactly one rising edge after the operands are applied. The bench drives inputs on the falling edge, lets one rising edge pass, and compares on the next falling edge, before the next stimulus goes on. One directed test changes the inputs and samples again before any rising edge. This shows the outputs still carry the earlier result and update only after the edge. A second directed test checks the reset values while reset is low, without waiting for any clock.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned IMM_W  = 16;
    localparam int unsigned OP_W   = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_NOR = 3'd4,
        OP_SLT = 3'd5,
        OP_SLL = 3'd6,
        OP_SRL = 3'd7
    } alu_op_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] lhs_i,
    input  logic [W-1:0] rhs_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         lt_o
);
    localparam int unsigned MSB = W - 1;

    logic [W-1:0] rhs_eff;
    logic         sign_differs;

    always_comb begin
        rhs_eff      = sub_i ? ~rhs_i : rhs_i;
        sum_o        = lhs_i + rhs_eff + {{(W-1){1'b0}}, sub_i};
        sign_differs = lhs_i[MSB] ^ rhs_i[MSB];
        // opposite signs: the negative one is smaller; same signs: the difference sign decides
        lt_o         = sign_differs ? lhs_i[MSB] : sum_o[MSB];
    end
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] lhs_i,
    input  logic [W-1:0] rhs_i,
    output logic [W-1:0] and_o,
    output logic [W-1:0] or_o,
    output logic [W-1:0] nor_o
);
    always_comb begin
        and_o = lhs_i & rhs_i;
        or_o  = lhs_i | rhs_i;
        nor_o = ~(lhs_i | rhs_i);
    end
endmodule

// File: rtl/alu_barrel.sv
module alu_barrel #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0]         data_i,
    input  logic [$clog2(W)-1:0] amt_i,
    output logic [W-1:0]         left_o,
    output logic [W-1:0]         right_o
);
    localparam int unsigned STAGES = $clog2(W);

    logic [W-1:0] lft [STAGES+1];
    logic [W-1:0] rgt [STAGES+1];

    assign lft[0] = data_i;
    assign rgt[0] = data_i;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        localparam int unsigned STEP = 1 << g;
        assign lft[g+1] = amt_i[g] ? (lft[g] << STEP) : lft[g];
        assign rgt[g+1] = amt_i[g] ? (rgt[g] >> STEP) : rgt[g];
    end

    assign left_o  = lft[STAGES];
    assign right_o = rgt[STAGES];
endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int unsigned W    = DATA_W,
    parameter int unsigned IMMW = IMM_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [OP_W-1:0]      op_i,
    input  logic                 imm_en_i,
    input  logic [W-1:0]         a_i,
    input  logic [W-1:0]         b_i,
    input  logic [IMMW-1:0]      imm_i,
    input  logic [$clog2(W)-1:0] shamt_i,
    output logic [W-1:0]         result_o,
    output logic                 zero_o
);
    localparam int unsigned PAD_W = W - IMMW;

    typedef struct packed {
        logic [W-1:0] res;
        logic         zf;
    } out_t;

    out_t    out_d, out_q;
    alu_op_e op;
    logic [W-1:0] opb;
    logic [W-1:0] sum, and_r, or_r, nor_r, shl, shr;
    logic         lt;
    logic         do_sub;

    always_comb begin
        op     = alu_op_e'(op_i);
        opb    = imm_en_i ? {{PAD_W{1'b0}}, imm_i} : b_i;
        do_sub = (op == OP_SUB) || (op == OP_SLT);
    end

    alu_addsub #(.W(W)) u_addsub (
        .lhs_i (a_i),
        .rhs_i (opb),
        .sub_i (do_sub),
        .sum_o (sum),
        .lt_o  (lt)
    );

    alu_bitwise #(.W(W)) u_bitwise (
        .lhs_i (a_i),
        .rhs_i (opb),
        .and_o (and_r),
        .or_o  (or_r),
        .nor_o (nor_r)
    );

    alu_barrel #(.W(W)) u_barrel (
        .data_i  (opb),
        .amt_i   (shamt_i),
        .left_o  (shl),
        .right_o (shr)
    );

    always_comb begin
        out_d = '0;
        unique case (op)
            OP_ADD, OP_SUB: out_d.res = sum;
            OP_AND:         out_d.res = and_r;
            OP_OR:          out_d.res = or_r;
            OP_NOR:         out_d.res = nor_r;
            OP_SLT:         out_d.res = {{(W-1){1'b0}}, lt};
            OP_SLL:         out_d.res = shl;
            OP_SRL:         out_d.res = shr;
            default:        out_d.res = '0;
        endcase
        out_d.zf = (out_d.res == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q.res <= '0;
            out_q.zf  <= 1'b1;
        end else begin
            out_q <= out_d;
        end
    end

    assign result_o = out_q.res;
    assign zero_o   = out_q.zf;
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
    parameter int unsigned W    = 32,
    parameter int unsigned IMMW = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [2:0]           op_i,
    input logic                 imm_en_i,
    input logic [W-1:0]         a_i,
    input logic [W-1:0]         b_i,
    input logic [IMMW-1:0]      imm_i,
    input logic [$clog2(W)-1:0] shamt_i,
    input logic [W-1:0]         result_o,
    input logic                 zero_o
);
    // R1
    add_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd0 && !imm_en_i) |=> (result_o == $past(a_i) + $past(b_i)));

    // R2
    sub_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd1 && !imm_en_i) |=> (result_o == $past(a_i) - $past(b_i)));

    // R4
    slt_bool_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd5) |=> (result_o[W-1:1] == '0));

    // R5
    sll_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd6 && shamt_i != '0) |=> !result_o[0]);

    // R6
    srl_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd7 && shamt_i != '0) |=> !result_o[W-1]);

    // R7
    andi_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd2 && imm_en_i) |=> (result_o[W-1:IMMW] == '0));

    // R8
    eq_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd1 && !imm_en_i && a_i == b_i) |=> zero_o);

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd3 && !imm_en_i) |=> (result_o == ($past(a_i) | $past(b_i))));
endmodule

bind alu_core alu_core_chk #(.W(W), .IMMW(IMMW)) u_alu_core_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (op_i),
    .imm_en_i (imm_en_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .imm_i    (imm_i),
    .shamt_i  (shamt_i),
    .result_o (result_o),
    .zero_o   (zero_o)
);

// File: tb/test_alu_core.sv
module test_alu_core;

    typedef struct packed {
        logic [3:0]  req;
        logic [2:0]  op;
        logic        imm_en;
        logic [31:0] a;
        logic [31:0] b;
        logic [15:0] imm;
        logic [4:0]  sh;
        logic [31:0] exp_res;
        logic        exp_z;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{4'd1, 3'd0, 1'b0, 32'h00000007, 32'h00000005, 16'h0, 5'd0, 32'h0000000C, 1'b0}, // R1
        '{4'd1, 3'd0, 1'b0, 32'hFFFFFFFF, 32'h00000001, 16'h0, 5'd0, 32'h00000000, 1'b1}, // R1 wrap, R8
        '{4'd2, 3'd1, 1'b0, 32'h00000005, 32'h00000007, 16'h0, 5'd0, 32'hFFFFFFFE, 1'b0}, // R2
        '{4'd2, 3'd1, 1'b0, 32'h12345678, 32'h12345678, 16'h0, 5'd0, 32'h00000000, 1'b1}, // R2 equal, R8
        '{4'd3, 3'd2, 1'b0, 32'h0000000D, 32'h80000009, 16'h0, 5'd0, 32'h00000009, 1'b0}, // R3 and
        '{4'd3, 3'd3, 1'b0, 32'h0000000D, 32'h80000009, 16'h0, 5'd0, 32'h8000000D, 1'b0}, // R3 or
        '{4'd3, 3'd4, 1'b0, 32'h0000000D, 32'h80000009, 16'h0, 5'd0, 32'h7FFFFFF2, 1'b0}, // R3 nor
        '{4'd3, 3'd4, 1'b0, 32'h0F0F0000, 32'h00000000, 16'h0, 5'd0, 32'hF0F0FFFF, 1'b0}, // R3 not
        '{4'd4, 3'd5, 1'b0, 32'hFFFFFFFF, 32'h00000001, 16'h0, 5'd0, 32'h00000001, 1'b0}, // R4 -1<1
        '{4'd4, 3'd5, 1'b0, 32'h00000001, 32'hFFFFFFFF, 16'h0, 5'd0, 32'h00000000, 1'b1}, // R4 1<-1 false
        '{4'd4, 3'd5, 1'b0, 32'h80000000, 32'h7FFFFFFF, 16'h0, 5'd0, 32'h00000001, 1'b0}, // R4 extremes
        '{4'd5, 3'd6, 1'b0, 32'hFFFFFFFF, 32'h0000010F, 16'h0, 5'd4, 32'h000010F0, 1'b0}, // R5, a ignored
        '{4'd5, 3'd6, 1'b0, 32'h00000000, 32'h00000003, 16'h0, 5'd31, 32'h80000000, 1'b0}, // R5 max
        '{4'd6, 3'd7, 1'b0, 32'hFFFFFFFF, 32'h000010F0, 16'h0, 5'd2, 32'h0000043C, 1'b0}, // R6, a ignored
        '{4'd6, 3'd7, 1'b0, 32'h00000000, 32'h80000000, 16'h0, 5'd31, 32'h00000001, 1'b0}, // R6 max
        '{4'd6, 3'd7, 1'b0, 32'h00000000, 32'hFFFFFFFF, 16'h0, 5'd0, 32'hFFFFFFFF, 1'b0}, // R6 zero shift
        '{4'd7, 3'd2, 1'b1, 32'hFFFFFFFF, 32'hDEADBEEF, 16'h1234, 5'd0, 32'h00001234, 1'b0}, // R7 andi
        '{4'd7, 3'd3, 1'b1, 32'hABCD0000, 32'hFFFFFFFF, 16'h00FF, 5'd0, 32'hABCD00FF, 1'b0}, // R7 ori
        '{4'd7, 3'd0, 1'b1, 32'h00000010, 32'h7FFFFFFF, 16'hFFFF, 5'd0, 32'h0001000F, 1'b0}  // R7 add
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_i = '0;
    logic        imm_en_i = 1'b0;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic [15:0] imm_i = '0;
    logic [4:0]  shamt_i = '0;
    logic [31:0] result_o;
    logic        zero_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    alu_core i_alu_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_i     (op_i),
        .imm_en_i (imm_en_i),
        .a_i      (a_i),
        .b_i      (b_i),
        .imm_i    (imm_i),
        .shamt_i  (shamt_i),
        .result_o (result_o),
        .zero_o   (zero_o)
    );

    task automatic check(input string tag, input logic [31:0] exp_r, input logic exp_z);
        total++;
        if (result_o !== exp_r || zero_o !== exp_z) begin
            bad++;
            $display("FAIL %s: result=%h zero=%b expected result=%h zero=%b",
                     tag, result_o, zero_o, exp_r, exp_z);
        end
    endtask

    task automatic apply(input vec_t v);
        op_i     = v.op;
        imm_en_i = v.imm_en;
        a_i      = v.a;
        b_i      = v.b;
        imm_i    = v.imm;
        shamt_i  = v.sh;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: result=%h zero=%b expected completion", result_o, zero_o);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R10: reset state, sampled while reset is low
        #12;
        check("R10 reset", 32'h0, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            @(posedge clk);
            @(negedge clk);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].exp_res, VECS[i].exp_z);
        end

        // R9: inputs change, no edge yet, outputs must hold the previous result
        apply('{4'd9, 3'd0, 1'b0, 32'h00000100, 32'h00000023, 16'h0, 5'd0, 32'h0, 1'b0});
        @(posedge clk);
        @(negedge clk);
        check("R9 registered add", 32'h00000123, 1'b0);
        a_i  = 32'h0;
        b_i  = 32'h0;
        op_i = 3'd1;
        #2;
        check("R9 hold before edge", 32'h00000123, 1'b0);
        @(posedge clk);
        @(negedge clk);
        check("R9 update after edge, R8 zero", 32'h00000000, 1'b1);

        // R7: b_i changes under imm_en have no effect
        apply('{4'd7, 3'd3, 1'b1, 32'h00000000, 32'h00000000, 16'h8001, 5'd0, 32'h0, 1'b0});
        @(posedge clk);
        @(negedge clk);
        check("R7 ori imm only", 32'h00008001, 1'b0);
        b_i = 32'hFFFFFFFF;
        @(posedge clk);
        @(negedge clk);
        check("R7 b ignored", 32'h00008001, 1'b0);

        // R10: asynchronous reset in mid-run
        #1;
        rst_n = 1'b0;
        #1;
        check("R10 async reset", 32'h0, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule